// File: doc/BRIEF.md
# Virtual Address Region and Access Checker

This block decides what happens to one 32-bit virtual data access before and after the page-table cache lookup. An access comes in with its address, direction and privilege level. The block first sorts it by address region and control state. The access then takes one of three paths:

- It passes straight through with a physical address.
- It is rejected as an address error.
- It is sent out as a translation request to an external TLB, which the block does not contain.

When the TLB answers, the block applies the page protection rules and the clean-page write rule. It then forms the physical address from the page frame and the page size.

Accesses enter on a valid/ready port. The block holds one access at a time, so `req_ready` is high only while it is idle. A translation request leaves on a second valid/ready port, and the lookup result comes back as a single-cycle `tlb_rsp_valid` pulse. The verdict (fault code and physical address) leaves on a third valid/ready port. That output is held stable for as long as `res_ready` stays low, and the next access is refused until the verdict has been taken.

On any TLB-class fault, the faulting address is latched. The page bits of an entry-high register are also replaced, while the entry-high register's 10-bit context field keeps its value. That context field is loaded from `ctx_tag` when `ctx_load` is high.

Top module: `va_access_checker`

## Requirements
- R1: A privileged access at or above 0xE0000000 completes with fault 0 and its address unchanged, whether translation is on or off.
- R2: A privileged access in 0x80000000..0xBFFFFFFF completes with fault 0 and its address ANDed with 0x1FFFFFFF.
- R3: A user access with bit 31 set gets fault code 1 (address error) and physical address 0. The exception is an address in 0xE0000000..0xE3FFFFFF while `cfg_sq_lock` is 0: that access completes with fault 0 and its address unchanged.
- R4: With `cfg_xlat_en` at 0, every access not covered by R1 to R3 completes with fault 0 and its address ANDed with 0x1FFFFFFF.
- R5: Every other access raises `tlb_req_valid` with `tlb_req_vaddr` equal to the access address. `tlb_req_use_asid` is 1 unless the access is privileged and `cfg_single_virt` is 1. Both outputs are held until `tlb_req_ready`.
- R6: `tlb_rsp_multi` gives fault 7, which takes precedence over everything else. Otherwise, a response with `tlb_rsp_hit` at 0 gives fault 2 for a read and fault 3 for a write.
- R7: A hit fails protection in three cases. A user read without `tlb_rsp_user` gives fault 4. A privileged write without `tlb_rsp_writable` gives fault 5. A user write lacking either of those two flags also gives fault 5. A privileged read never fails protection.
- R8: A write that passes protection but whose entry has `tlb_rsp_dirty` at 0 gives fault 6. A protection failure takes precedence over this fault.
- R9: A hit with no fault returns (frame & M) | (vaddr & ~M), where frame is {`tlb_rsp_ppn`, 10'b0}. M is all ones above bit 10, 12, 16 or 20 for `tlb_rsp_size` 0, 1, 2 or 3 respectively. Every faulting verdict carries physical address 0.
- R10: Faults 2 to 7 load `flt_vaddr` with the access address and load bits 31..10 of `flt_entry_hi` with the address bits 31..10. Bits 9..0 of `flt_entry_hi` are kept. Fault 1 and fault-free verdicts leave both registers unchanged. A `ctx_load` pulse writes `ctx_tag` into bits 9..0. Both registers reset to 0.
- R11: Timing and flow control work as follows.
  - After reset, `req_ready` is 1 and `res_valid` is 0.
  - `res_valid` rises in the cycle after the request is accepted when no lookup is needed, or in the cycle after `tlb_rsp_valid` when one is.
  - The verdict stays stable while `res_ready` is low.
  - `req_ready` stays low while a verdict is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block idle, request taken |
| req_addr | input | 32 | Virtual address of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged mode |
| cfg_xlat_en | input | 1 | Address translation enable |
| cfg_single_virt | input | 1 | Single virtual space mode |
| cfg_sq_lock | input | 1 | Blocks user access to the store-queue window |
| tlb_req_valid | output | 1 | Translation request valid |
| tlb_req_ready | input | 1 | TLB takes the request |
| tlb_req_vaddr | output | 32 | Address to look up |
| tlb_req_use_asid | output | 1 | Lookup must compare the address space tag |
| tlb_rsp_valid | input | 1 | Lookup result pulse |
| tlb_rsp_hit | input | 1 | At least one entry matched |
| tlb_rsp_multi | input | 1 | More than one entry matched |
| tlb_rsp_user | input | 1 | Entry flag: user accessible |
| tlb_rsp_writable | input | 1 | Entry flag: writable |
| tlb_rsp_dirty | input | 1 | Entry flag: page already written |
| tlb_rsp_size | input | 2 | Page size code (0 = 1K, 1 = 4K, 2 = 64K, 3 = 1M) |
| tlb_rsp_ppn | input | 22 | Page frame bits 31..10 |
| res_valid | output | 1 | Verdict valid |
| res_ready | input | 1 | Consumer takes the verdict |
| res_fault | output | 3 | Fault code, 0 = none |
| res_paddr | output | 32 | Physical address, 0 on fault |
| ctx_load | input | 1 | Load the context field of the entry-high register |
| ctx_tag | input | 10 | Context value to load |
| flt_vaddr | output | 32 | Last TLB-class faulting address |
| flt_entry_hi | output | 32 | Entry-high register: fault page bits and context |

## Verification
Privileged accesses are sent to each region both with translation on and with it off, which shows that the region checks are evaluated before the translation enable. User accesses are sent inside the store-queue window, just past it and with the lock set, which separates the single legal high user window from address errors. Translated accesses sweep the four page sizes with frame and offset patterns that differ on each side of every mask boundary, and every flag combination is tried in both modes and both directions. This isolates the protection rule from the dirty rule and shows which of the two takes precedence. Fault-register checks interleave address errors and context loads with TLB faults, so that each register update is shown to come from the right cause.

// File: rtl/va_chk_pkg.sv
package va_chk_pkg;
  localparam int VA_W   = 32;
  localparam int PG_LSB = 10;
  localparam int PPN_W  = VA_W - PG_LSB;
  localparam int FLT_W  = 3;

  typedef enum logic [FLT_W-1:0] {
    FLT_NONE    = 3'd0,
    FLT_ADDR    = 3'd1,
    FLT_MISS_RD = 3'd2,
    FLT_MISS_WR = 3'd3,
    FLT_PROT_RD = 3'd4,
    FLT_PROT_WR = 3'd5,
    FLT_INIT_WR = 3'd6,
    FLT_MULTI   = 3'd7
  } fault_e;

  typedef enum logic [1:0] {
    CLS_PASS  = 2'd0,
    CLS_ADERR = 2'd1,
    CLS_XLATE = 2'd2
  } cls_e;

  typedef struct packed {
    logic             hit;
    logic             multi;
    logic             usr;
    logic             wr;
    logic             dirty;
    logic [1:0]       size;
    logic [PPN_W-1:0] ppn;
  } tlb_rsp_t;
endpackage

// File: rtl/va_region_decode.sv
module va_region_decode
  import va_chk_pkg::*;
#(
  parameter logic [VA_W-1:0] HI_PASS_BASE = 32'hE000_0000,
  parameter logic [VA_W-1:0] XLAT_HI_BASE = 32'hC000_0000,
  parameter logic [VA_W-1:0] SQ_END       = 32'hE400_0000,
  parameter logic [VA_W-1:0] EXT_MASK     = 32'h1FFF_FFFF
) (
  input  logic [VA_W-1:0] addr,
  input  logic            priv,
  input  logic            xlat_en,
  input  logic            sq_lock,
  output cls_e            cls,
  output logic [VA_W-1:0] pass_addr
);
  logic top_set, priv_hi, priv_low, user_hi, in_sq;

  assign top_set  = addr[VA_W-1];
  assign priv_hi  = priv && (addr >= HI_PASS_BASE);
  assign priv_low = priv && top_set && (addr < XLAT_HI_BASE);
  assign user_hi  = !priv && top_set;
  assign in_sq    = (addr >= HI_PASS_BASE) && (addr < SQ_END);

  always_comb begin
    cls       = CLS_XLATE;
    pass_addr = '0;
    if (priv_hi) begin
      cls       = CLS_PASS;
      pass_addr = addr;
    end else if (priv_low) begin
      cls       = CLS_PASS;
      pass_addr = addr & EXT_MASK;
    end else if (user_hi) begin
      if (in_sq && !sq_lock) begin
        cls       = CLS_PASS;
        pass_addr = addr;
      end else begin
        cls = CLS_ADERR;
      end
    end else if (!xlat_en) begin
      cls       = CLS_PASS;
      pass_addr = addr & EXT_MASK;
    end
  end
endmodule

// File: rtl/va_tlb_judge.sv
module va_tlb_judge
  import va_chk_pkg::*;
#(
  parameter int SZ0_LSB = 10,
  parameter int SZ1_LSB = 12,
  parameter int SZ2_LSB = 16,
  parameter int SZ3_LSB = 20
) (
  input  logic [VA_W-1:0] vaddr,
  input  logic            write,
  input  logic            priv,
  input  tlb_rsp_t        rsp,
  output fault_e          fault,
  output logic [VA_W-1:0] paddr
);
  localparam logic [VA_W-1:0] ALL1 = '1;

  logic [VA_W-1:0] page_mask, frame;
  logic            deny_rd, deny_wr;

  always_comb begin
    unique case (rsp.size)
      2'd0:    page_mask = ALL1 << SZ0_LSB;
      2'd1:    page_mask = ALL1 << SZ1_LSB;
      2'd2:    page_mask = ALL1 << SZ2_LSB;
      default: page_mask = ALL1 << SZ3_LSB;
    endcase
  end

  assign frame   = {rsp.ppn, {PG_LSB{1'b0}}};
  assign deny_rd = !priv && !rsp.usr;
  assign deny_wr = !rsp.wr || (!priv && !rsp.usr);

  always_comb begin
    if (rsp.multi)            fault = FLT_MULTI;
    else if (!rsp.hit)        fault = write ? FLT_MISS_WR : FLT_MISS_RD;
    else if (!write)          fault = deny_rd ? FLT_PROT_RD : FLT_NONE;
    else if (deny_wr)         fault = FLT_PROT_WR;
    else if (!rsp.dirty)      fault = FLT_INIT_WR;
    else                      fault = FLT_NONE;
  end

  assign paddr = (fault == FLT_NONE) ? ((frame & page_mask) | (vaddr & ~page_mask)) : '0;
endmodule

// File: rtl/va_fault_regs.sv
module va_fault_regs
  import va_chk_pkg::*;
#(
  parameter int CTX_W = PG_LSB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [VA_W-1:0]  cap_addr,
  input  logic             ctx_load,
  input  logic [CTX_W-1:0] ctx_tag,
  output logic [VA_W-1:0]  flt_vaddr,
  output logic [VA_W-1:0]  flt_entry_hi
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flt_vaddr    <= '0;
      flt_entry_hi <= '0;
    end else begin
      if (cap_en) begin
        flt_vaddr                   <= cap_addr;
        flt_entry_hi[VA_W-1:CTX_W]  <= cap_addr[VA_W-1:CTX_W];
      end
      if (ctx_load) flt_entry_hi[CTX_W-1:0] <= ctx_tag;
    end
  end

  // R10: the context field survives a fault capture
  p_ctx_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en && !ctx_load |=> flt_entry_hi[CTX_W-1:0] == $past(flt_entry_hi[CTX_W-1:0]));

  // R10: no capture means the fault address holds
  p_fa_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(flt_vaddr));
endmodule

// File: rtl/va_access_checker.sv
module va_access_checker
  import va_chk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic              req_write,
  input  logic              req_priv,
  input  logic              cfg_xlat_en,
  input  logic              cfg_single_virt,
  input  logic              cfg_sq_lock,
  output logic              tlb_req_valid,
  input  logic              tlb_req_ready,
  output logic [31:0]       tlb_req_vaddr,
  output logic              tlb_req_use_asid,
  input  logic              tlb_rsp_valid,
  input  logic              tlb_rsp_hit,
  input  logic              tlb_rsp_multi,
  input  logic              tlb_rsp_user,
  input  logic              tlb_rsp_writable,
  input  logic              tlb_rsp_dirty,
  input  logic [1:0]        tlb_rsp_size,
  input  logic [21:0]       tlb_rsp_ppn,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [2:0]        res_fault,
  output logic [31:0]       res_paddr,
  input  logic              ctx_load,
  input  logic [9:0]        ctx_tag,
  output logic [31:0]       flt_vaddr,
  output logic [31:0]       flt_entry_hi
);
  typedef enum logic [1:0] {ST_IDLE, ST_TREQ, ST_TWAIT, ST_RESP} st_e;

  st_e             st_q;
  logic [VA_W-1:0] a_addr_q;
  logic            a_wr_q, a_priv_q, a_sv_q;
  fault_e          fault_q;
  logic [VA_W-1:0] paddr_q;

  cls_e            dec_cls;
  logic [VA_W-1:0] dec_paddr;
  fault_e          jdg_fault;
  logic [VA_W-1:0] jdg_paddr;
  tlb_rsp_t        rsp;
  logic            acc_req, acc_rsp;

  va_region_decode u_dec (
    .addr      (req_addr),
    .priv      (req_priv),
    .xlat_en   (cfg_xlat_en),
    .sq_lock   (cfg_sq_lock),
    .cls       (dec_cls),
    .pass_addr (dec_paddr)
  );

  assign rsp = '{hit: tlb_rsp_hit, multi: tlb_rsp_multi, usr: tlb_rsp_user,
                 wr: tlb_rsp_writable, dirty: tlb_rsp_dirty,
                 size: tlb_rsp_size, ppn: tlb_rsp_ppn};

  va_tlb_judge u_jdg (
    .vaddr (a_addr_q),
    .write (a_wr_q),
    .priv  (a_priv_q),
    .rsp   (rsp),
    .fault (jdg_fault),
    .paddr (jdg_paddr)
  );

  assign acc_req = (st_q == ST_IDLE) && req_valid;
  assign acc_rsp = (st_q == ST_TWAIT) && tlb_rsp_valid;

  va_fault_regs u_flt (
    .clk          (clk),
    .rst_n        (rst_n),
    .cap_en       (acc_rsp && (jdg_fault != FLT_NONE)),
    .cap_addr     (a_addr_q),
    .ctx_load     (ctx_load),
    .ctx_tag      (ctx_tag),
    .flt_vaddr    (flt_vaddr),
    .flt_entry_hi (flt_entry_hi)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      a_addr_q <= '0;
      a_wr_q   <= 1'b0;
      a_priv_q <= 1'b0;
      a_sv_q   <= 1'b0;
      fault_q  <= FLT_NONE;
      paddr_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (acc_req) begin
          a_addr_q <= req_addr;
          a_wr_q   <= req_write;
          a_priv_q <= req_priv;
          a_sv_q   <= cfg_single_virt;
          if (dec_cls == CLS_XLATE) begin
            st_q <= ST_TREQ;
          end else begin
            fault_q <= (dec_cls == CLS_ADERR) ? FLT_ADDR : FLT_NONE;
            paddr_q <= dec_paddr;
            st_q    <= ST_RESP;
          end
        end
        ST_TREQ:  if (tlb_req_ready) st_q <= ST_TWAIT;
        ST_TWAIT: if (tlb_rsp_valid) begin
          fault_q <= jdg_fault;
          paddr_q <= jdg_paddr;
          st_q    <= ST_RESP;
        end
        default:  if (res_ready) st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready        = (st_q == ST_IDLE);
  assign tlb_req_valid    = (st_q == ST_TREQ);
  assign tlb_req_vaddr    = a_addr_q;
  assign tlb_req_use_asid = !a_sv_q || !a_priv_q;
  assign res_valid        = (st_q == ST_RESP);
  assign res_fault        = fault_q;
  assign res_paddr        = paddr_q;

  // R11: verdict held under back-pressure
  p_res_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_fault) && $stable(res_paddr));

  // R11: no new access while a verdict waits
  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && res_valid));

  // R11: verdict one cycle after the lookup result
  p_rsp_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rsp |=> res_valid);

  // R5: lookup request held until taken
  p_treq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_req_valid && !tlb_req_ready |=> tlb_req_valid && $stable(tlb_req_vaddr)
                                        && $stable(tlb_req_use_asid));

  // R9: faulting verdicts carry a zero address
  p_fault_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (res_fault != 3'd0) |-> res_paddr == 32'd0);
endmodule

// File: tb/va_access_checker_bench.sv
module va_access_checker_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 0, req_write = 0, req_priv = 0;
  logic [31:0] req_addr = 0;
  logic        cfg_xlat_en = 0, cfg_single_virt = 0, cfg_sq_lock = 0;
  logic        tlb_req_ready = 0, tlb_rsp_valid = 0, tlb_rsp_hit = 0, tlb_rsp_multi = 0;
  logic        tlb_rsp_user = 0, tlb_rsp_writable = 0, tlb_rsp_dirty = 0;
  logic [1:0]  tlb_rsp_size = 0;
  logic [21:0] tlb_rsp_ppn = 0;
  logic        res_ready;
  logic        ctx_load = 0;
  logic [9:0]  ctx_tag = 0;
  logic        req_ready, tlb_req_valid, tlb_req_use_asid, res_valid;
  logic [31:0] tlb_req_vaddr, res_paddr, flt_vaddr, flt_entry_hi;
  logic [2:0]  res_fault;

  va_access_checker u_va_access_checker (.*);

  int n_run = 0, n_fail = 0;
  logic [2:0]  exp_f[$];
  logic [31:0] exp_p[$];
  string       exp_t[$];
  logic [31:0] m_fa = 0;
  logic [21:0] m_hi = 0;
  logic [9:0]  m_lo = 0;

  task automatic chk(input bit ok, input string tg, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tg, act, exp);
    end
  endtask

  logic [7:0] rr_cnt = 0;
  always @(posedge clk) begin
    rr_cnt    <= rr_cnt + 8'd1;
    res_ready <= rst_n && (rr_cnt[1:0] != 2'd2);
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      if (exp_f.size() == 0) begin
        chk(0, "R11 unexpected verdict", {29'd0, res_fault}, 32'd0);
      end else begin
        string t;
        logic [2:0] ef;
        logic [31:0] ep;
        t = exp_t.pop_front(); ef = exp_f.pop_front(); ep = exp_p.pop_front();
        chk(res_fault == ef, {t, " fault"}, {29'd0, res_fault}, {29'd0, ef});
        chk(res_paddr == ep, {t, " paddr"}, res_paddr, ep);
      end
    end
  end

  function automatic logic [31:0] xpa(input logic [31:0] a, input logic [1:0] sz, input logic [21:0] ppn);
    int lsb;
    logic [31:0] m;
    lsb = (sz == 0) ? 10 : (sz == 1) ? 12 : (sz == 2) ? 16 : 20;
    m = 32'hFFFF_FFFF << lsb;
    return ({ppn, 10'd0} & m) | (a & ~m);
  endfunction

  task automatic access(input logic [31:0] a, input bit wr, pv, xl, sv, sql, input string tg,
                        input bit tl, hit, mul, usr, wrf, dty, input logic [1:0] sz,
                        input logic [21:0] ppn, input logic [2:0] ef, input logic [31:0] ep);
    @(negedge clk);
    req_addr = a; req_write = wr; req_priv = pv;
    cfg_xlat_en = xl; cfg_single_virt = sv; cfg_sq_lock = sql;
    exp_t.push_back(tg); exp_f.push_back(ef); exp_p.push_back(ep);
    req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    if (!tl) begin
      chk(res_valid == 1'b1, {tg, " R11 latency"}, {31'd0, res_valid}, 32'd1);
      chk(tlb_req_valid == 1'b0, {tg, " R5 no lookup"}, {31'd0, tlb_req_valid}, 32'd0);
    end else begin
      chk(tlb_req_valid == 1'b1, {tg, " R5 lookup raised"}, {31'd0, tlb_req_valid}, 32'd1);
      repeat (2) @(negedge clk);
      chk(tlb_req_vaddr == a, {tg, " R5 vaddr"}, tlb_req_vaddr, a);
      chk(tlb_req_use_asid == (!sv || !pv), {tg, " R5 asid"}, {31'd0, tlb_req_use_asid},
          {31'd0, (!sv || !pv)});
      tlb_req_ready = 1;
      @(negedge clk);
      tlb_req_ready = 0;
      chk(res_valid == 1'b0, {tg, " R11 waiting"}, {31'd0, res_valid}, 32'd0);
      @(negedge clk);
      tlb_rsp_hit = hit; tlb_rsp_multi = mul; tlb_rsp_user = usr; tlb_rsp_writable = wrf;
      tlb_rsp_dirty = dty; tlb_rsp_size = sz; tlb_rsp_ppn = ppn; tlb_rsp_valid = 1;
      @(negedge clk);
      tlb_rsp_valid = 0;
      chk(res_valid == 1'b1, {tg, " R11 rsp latency"}, {31'd0, res_valid}, 32'd1);
    end
    while (exp_f.size() != 0) @(negedge clk);
    if (ef >= 3'd2) begin m_fa = a; m_hi = a[31:10]; end
    @(negedge clk);
    chk(flt_vaddr == m_fa, {tg, " R10 fault addr"}, flt_vaddr, m_fa);
    chk(flt_entry_hi == {m_hi, m_lo}, {tg, " R10 entry hi"}, flt_entry_hi, {m_hi, m_lo});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 reset ready", {31'd0, req_ready}, 32'd1);
    chk(res_valid == 1'b0, "R11 reset valid", {31'd0, res_valid}, 32'd0);
    chk(flt_entry_hi == 32'd0, "R10 reset entry hi", flt_entry_hi, 32'd0);
    // R1
    access(32'hE000_1234, 0, 1, 1, 0, 0, "R1", 0, 0,0,0,0,0, 0, 0, 3'd0, 32'hE000_1234);
    access(32'hFFFF_FF00, 1, 1, 0, 0, 0, "R1", 0, 0,0,0,0,0, 0, 0, 3'd0, 32'hFFFF_FF00);
    // R2
    access(32'h8C00_0100, 1, 1, 1, 0, 0, "R2", 0, 0,0,0,0,0, 0, 0, 3'd0, 32'h0C00_0100);
    access(32'hA123_4567, 0, 1, 0, 0, 0, "R2", 0, 0,0,0,0,0, 0, 0, 3'd0, 32'h0123_4567);
    // R3
    access(32'h8000_0000, 0, 0, 1, 0, 0, "R3", 0, 0,0,0,0,0, 0, 0, 3'd1, 32'h0);
    access(32'hE000_0040, 0, 0, 1, 0, 0, "R3", 0, 0,0,0,0,0, 0, 0, 3'd0, 32'hE000_0040);
    access(32'hE3FF_FFFC, 1, 0, 1, 0, 1, "R3", 0, 0,0,0,0,0, 0, 0, 3'd1, 32'h0);
    access(32'hE400_0000, 0, 0, 0, 0, 0, "R3", 0, 0,0,0,0,0, 0, 0, 3'd1, 32'h0);
    // R4
    access(32'h1234_5678, 0, 0, 0, 0, 0, "R4", 0, 0,0,0,0,0, 0, 0, 3'd0, 32'h1234_5678);
    access(32'hC123_4567, 1, 1, 0, 0, 0, "R4", 0, 0,0,0,0,0, 0, 0, 3'd0, 32'h0123_4567);
    // R5 / R9
    access(32'h0040_1234, 0, 0, 1, 0, 0, "R9", 1, 1,0,1,0,0, 2'd0, 22'h00ABCD, 3'd0,
           xpa(32'h0040_1234, 2'd0, 22'h00ABCD));
    access(32'h0040_1234, 0, 1, 1, 1, 0, "R5", 1, 1,0,0,0,0, 2'd1, 22'h3FFFFF, 3'd0,
           xpa(32'h0040_1234, 2'd1, 22'h3FFFFF));
    access(32'h1234_5678, 1, 1, 1, 0, 0, "R9", 1, 1,0,0,1,1, 2'd2, 22'h012345, 3'd0,
           xpa(32'h1234_5678, 2'd2, 22'h012345));
    access(32'h7FF8_9ABC, 0, 0, 1, 1, 0, "R9", 1, 1,0,1,0,0, 2'd3, 22'h2AAAAA, 3'd0,
           xpa(32'h7FF8_9ABC, 2'd3, 22'h2AAAAA));
    // R6
    access(32'h0000_2000, 0, 0, 1, 0, 0, "R6", 1, 0,0,1,1,1, 0, 22'h1, 3'd2, 32'h0);
    access(32'h0000_4400, 1, 1, 1, 0, 0, "R6", 1, 0,0,1,1,1, 0, 22'h1, 3'd3, 32'h0);
    access(32'hC000_0800, 0, 1, 1, 0, 0, "R6", 1, 1,1,1,1,1, 0, 22'h1, 3'd7, 32'h0);
    // R7
    access(32'h0010_0000, 0, 0, 1, 0, 0, "R7", 1, 1,0,0,1,1, 0, 22'h5, 3'd4, 32'h0);
    access(32'h0010_0400, 0, 1, 1, 0, 0, "R7", 1, 1,0,0,0,0, 0, 22'h5, 3'd0,
           xpa(32'h0010_0400, 2'd0, 22'h5));
    access(32'h0010_0800, 1, 1, 1, 0, 0, "R7", 1, 1,0,1,0,1, 0, 22'h5, 3'd5, 32'h0);
    access(32'h0010_0C00, 1, 0, 1, 0, 0, "R7", 1, 1,0,0,1,1, 0, 22'h5, 3'd5, 32'h0);
    access(32'h0010_1004, 1, 0, 1, 0, 0, "R7", 1, 1,0,1,1,1, 0, 22'h7, 3'd0,
           xpa(32'h0010_1004, 2'd0, 22'h7));
    // R8
    access(32'h0020_0000, 1, 1, 1, 0, 0, "R8", 1, 1,0,0,1,0, 0, 22'h9, 3'd6, 32'h0);
    access(32'h0020_0400, 1, 0, 1, 0, 0, "R8", 1, 1,0,1,0,0, 0, 22'h9, 3'd5, 32'h0);
    // R10: address error leaves fault registers alone
    access(32'h9000_0000, 0, 0, 1, 0, 0, "R10", 0, 0,0,0,0,0, 0, 0, 3'd1, 32'h0);
    // R10: context load, then a fault keeps it
    @(negedge clk);
    ctx_tag = 10'h2A5; ctx_load = 1;
    @(negedge clk);
    ctx_load = 0; m_lo = 10'h2A5;
    chk(flt_entry_hi == {m_hi, m_lo}, "R10 ctx load", flt_entry_hi, {m_hi, m_lo});
    access(32'h0055_5400, 0, 0, 1, 0, 0, "R10", 1, 0,0,0,0,0, 0, 0, 3'd2, 32'h0);
    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule